// File: doc/BRIEF.md
# Synchronous Burst Pseudo-SRAM Read Controller

This block turns host read requests into continuous synchronous burst reads on a 16-bit pseudo-static RAM. It streams the returned words to a consumer through a valid/ready port. A request carries a start word address and a word count. The controller opens a burst by pulling chip enable low and giving a single address-valid strobe. It then waits out the initial latency that the 3-bit latency code selects, and from that point takes one word per clock from the data bus.

The memory may hold WAIT low, meaning "no data this cycle", while it crosses an internal row. The controller captures data only in cycles where WAIT is high, so a stall is absorbed with no loss or duplication. If WAIT stays low longer than twice the latency code, the transfer is abandoned and an error is flagged. The chip-enable low time has a ceiling. Consumer back-pressure is bounded by a two-entry output buffer. Either condition ends the burst early, and the burst is re-opened later at the first word not yet captured. The memory clock runs freely and is never gated.

Top module: `psram_burst_rd`

## Requirements
- R1: While reset is held and after it is released with no request pending, the outputs are: chip enable, address strobe and output enable high (inactive), `rd_valid` low, `req_ready` high and `xfer_err` low.
- R2: Each burst opens with exactly one cycle of `mem_adv_n` low, in the cycle where `mem_ce_n` first goes low, with `mem_addr` equal to the next word to fetch. `mem_oe_n` is low in every later cycle of that chip-enable low period. Throughout the burst `mem_we_n` is high and `mem_lb_n`/`mem_ub_n` are low.
- R3: Count the strobe cycle as cycle 0. Cycles 1 to LC are never captured, whatever level WAIT has. Cycle LC+1 is the first cycle in which a word may be captured. LC is the value on `lat_code`.
- R4: From cycle LC+1 on, a word is captured in every cycle where `mem_wait_n` is 1, and in no cycle where it is 0.
- R5: A row-boundary stall that holds `mem_wait_n` at 0 for up to 2×LC consecutive data cycles completes the transfer with `xfer_err` low and no lost or repeated word.
- R6: If `mem_wait_n` is still 0 in the (2×LC+1)-th consecutive data cycle, the controller raises chip enable, drops the rest of the transfer, sets `xfer_err` and returns to ready. `xfer_err` clears when the next request is accepted.
- R7: `mem_ce_n` never stays low for more than `CEM_CYCLES` consecutive cycles. After it rises, the burst re-opens at the first word not yet captured.
- R8: A request of N words delivers exactly N words on the read port, in rising address order, each equal to the memory content at its address.
- R9: When consumer back-pressure fills the two-entry buffer, the burst ends with no word dropped or overwritten. It restarts at the next word address once space frees.
- R10: A request with a word count of 0 is accepted and produces no memory cycle.
- R11: `mem_clk` follows `clk` at all times.
- R12: `req_ready` is low whenever chip enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lat_code | input | 3 | Latency code LC; first word in cycle LC+1 after the strobe |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_addr | input | ADDR_W | Start word address |
| req_len | input | LEN_W | Number of words to read |
| rd_valid | output | 1 | Read word available |
| rd_ready | input | 1 | Consumer takes the word |
| rd_data | output | DATA_W | Read word |
| xfer_err | output | 1 | WAIT timeout on the last transfer |
| mem_clk | output | 1 | Free-running memory clock |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_adv_n | output | 1 | Address valid strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, held high |
| mem_lb_n | output | 1 | Lower byte enable, held low |
| mem_ub_n | output | 1 | Upper byte enable, held low |
| mem_addr | output | ADDR_W | Word address |
| mem_dq | input | DATA_W | Read data from memory |
| mem_wait_n | input | 1 | WAIT, low means data not valid |

## Verification
The bench drives the read path against a behavioural memory under several patterns. Latency codes 0, 2 and 3 are used, and one run holds WAIT high during latency, which separates a fixed latency count from one that trusts WAIT too early. Row stalls of exactly 2×LC and 2×LC+1 cycles mark the boundary between tolerance and timeout, and garbage on the data bus during stall cycles exposes any capture taken while WAIT is low. A 100-word transfer forces chip-enable splits, and alternating and bursty consumer ready exercise the buffer-full split. In both cases the memory model checks that every re-opened burst starts at the next uncaptured address.

// File: rtl/psram_burst_rd.sv
module psram_burst_rd #(
  parameter int ADDR_W     = 22,
  parameter int DATA_W     = 16,
  parameter int LEN_W      = 16,
  parameter int CEM_CYCLES = 40,
  localparam int CEL_W     = $clog2(CEM_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        lat_code,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [DATA_W-1:0] rd_data,
  output logic              xfer_err,
  output logic              mem_clk,
  output logic              mem_ce_n,
  output logic              mem_adv_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic              mem_lb_n,
  output logic              mem_ub_n,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_dq,
  input  logic              mem_wait_n
);

  typedef enum logic [2:0] {S_IDLE, S_GAP, S_ADV, S_LAT, S_DATA} st_t;

  localparam logic [ADDR_W-1:0] A_ONE = 1;
  localparam logic [LEN_W-1:0]  L_ONE = 1;
  localparam logic [CEL_W-1:0]  C_ONE = 1;
  localparam logic [CEL_W-1:0]  C_LIM = CEL_W'(CEM_CYCLES - 1);

  st_t               st;
  logic [ADDR_W-1:0] cur_addr;
  logic [LEN_W-1:0]  remain;
  logic [2:0]        lat_cnt;
  logic [CEL_W-1:0]  cel_cnt;
  logic [3:0]        wcnt;
  logic              err_q;
  logic [DATA_W-1:0] buf_q [2];
  logic              wp, rp;
  logic [1:0]        cnt, cnt_nxt;
  logic              cap, pop, last, cem_hit, wd_hit, full_hit;

  assign mem_clk   = clk;
  assign mem_ce_n  = !(st == S_ADV || st == S_LAT || st == S_DATA);
  assign mem_adv_n = (st != S_ADV);
  assign mem_oe_n  = !(st == S_LAT || st == S_DATA);
  assign mem_we_n  = 1'b1;
  assign mem_lb_n  = 1'b0;
  assign mem_ub_n  = 1'b0;
  assign mem_addr  = cur_addr;
  assign req_ready = (st == S_IDLE);
  assign xfer_err  = err_q;

  assign rd_valid = (cnt != 2'd0);
  assign rd_data  = buf_q[rp];
  assign pop      = rd_valid && rd_ready;
  assign cap      = (st == S_DATA) && mem_wait_n;
  assign cnt_nxt  = cnt + {1'b0, cap} - {1'b0, pop};
  assign last     = cap && (remain == L_ONE);
  assign cem_hit  = (cel_cnt == C_LIM);
  assign wd_hit   = (st == S_DATA) && !mem_wait_n && (wcnt == {lat_code, 1'b0});
  assign full_hit = cap && (cnt_nxt == 2'd2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cur_addr <= '0;
      remain   <= '0;
      lat_cnt  <= '0;
      err_q    <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          cur_addr <= req_addr;
          remain   <= req_len;
          err_q    <= 1'b0;
          if (req_len != '0) st <= S_ADV;
        end
        S_GAP: if (cnt_nxt != 2'd2) st <= S_ADV;
        S_ADV: begin
          lat_cnt <= lat_code;
          st      <= (lat_code == 3'd0) ? S_DATA : S_LAT;
        end
        S_LAT: begin
          lat_cnt <= lat_cnt - 3'd1;
          if (cem_hit)               st <= S_GAP;
          else if (lat_cnt == 3'd1)  st <= S_DATA;
        end
        S_DATA: begin
          if (cap) begin
            cur_addr <= cur_addr + A_ONE;
            remain   <= remain - L_ONE;
          end
          if (last) st <= S_IDLE;
          else if (wd_hit) begin
            err_q <= 1'b1;
            st    <= S_IDLE;
          end else if (cem_hit || full_hit) st <= S_GAP;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cel_cnt <= '0;
      wcnt    <= '0;
    end else begin
      cel_cnt <= mem_ce_n ? '0 : cel_cnt + C_ONE;
      wcnt    <= ((st == S_DATA) && !mem_wait_n) ? wcnt + 4'd1 : 4'd0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= 1'b0;
      rp  <= 1'b0;
      cnt <= 2'd0;
    end else begin
      if (cap) wp <= ~wp;
      if (pop) rp <= ~rp;
      cnt <= cnt_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (cap) buf_q[wp] <= mem_dq;
  end

  p_adv_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_adv_n |=> mem_adv_n);
  p_adv_with_ce_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_adv_n |-> (!mem_ce_n && mem_oe_n));
  p_oe_after_adv_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_adv_n |=> (mem_ce_n || !mem_oe_n));
  p_open_with_adv_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_ce_n) |-> !mem_adv_n);
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cap |-> (cnt != 2'd2));
  p_hold_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));
  p_err_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfer_err) |-> (mem_ce_n && req_ready));
  p_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ce_n |-> !req_ready);

endmodule

// File: tb/psram_burst_rd_tb.sv
module psram_burst_rd_tb;
  localparam int CEM = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  lat_code = 3'd2;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [21:0] req_addr = '0;
  logic [15:0] req_len = '0;
  logic        rd_valid, rd_ready;
  logic [15:0] rd_data;
  logic        xfer_err, mem_clk, mem_ce_n, mem_adv_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n;
  logic [21:0] mem_addr;
  logic [15:0] mem_dq = 16'hDEAD;
  logic        mem_wait_n = 1'b1;

  psram_burst_rd #(.ADDR_W(22), .DATA_W(16), .LEN_W(16), .CEM_CYCLES(CEM)) u_dut (
    .clk(clk), .rst_n(rst_n), .lat_code(lat_code), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_data(rd_data), .xfer_err(xfer_err), .mem_clk(mem_clk), .mem_ce_n(mem_ce_n),
    .mem_adv_n(mem_adv_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_lb_n(mem_lb_n),
    .mem_ub_n(mem_ub_n), .mem_addr(mem_addr), .mem_dq(mem_dq), .mem_wait_n(mem_wait_n));

  always #10 clk = ~clk;

  int vectors = 0, fails = 0, cyc = 0;
  int rd_mode = 0, stall_len = 0, lat_hi = 0;
  int rx = 0, adv_count = 0, ce_run = 0, ce_max = 0, pin_viol = 0, addr_viol = 0;
  logic [21:0] exp_next = '0, exp_rd = '0, maddr = '0;
  int m_lat = 0, m_stall = 0;
  bit m_on = 0, m_first = 0, m_did = 0;

  function automatic logic [15:0] pat(input logic [21:0] a);
    return a[15:0] ^ {a[21:16], 10'h1A5};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  // behavioural memory: sets WAIT/DQ for the current cycle at mid-cycle
  always @(negedge clk) begin
    if (mem_ce_n) begin
      mem_wait_n = 1'b1; mem_dq = 16'hDEAD; m_on = 0; ce_run = 0;
    end else begin
      ce_run++;
      if (ce_run > ce_max) ce_max = ce_run;
      if (mem_we_n !== 1'b1 || mem_lb_n !== 1'b0 || mem_ub_n !== 1'b0) pin_viol++;
      if (!mem_adv_n) begin
        if (m_on || mem_oe_n !== 1'b1) pin_viol++;
        adv_count++;
        if (mem_addr !== exp_next) addr_viol++;
        maddr = mem_addr; m_lat = lat_code; m_first = 1; m_did = 0; m_stall = 0; m_on = 1;
        mem_wait_n = 1'b0; mem_dq = 16'hDEAD;
      end else begin
        if (!m_on || mem_oe_n !== 1'b0) pin_viol++;
        if (m_lat > 0) begin
          m_lat--; mem_wait_n = (lat_hi != 0); mem_dq = 16'hBAD0;
        end else begin
          if (!m_first && maddr[3:0] == 4'h0 && !m_did) begin m_did = 1; m_stall = stall_len; end
          if (m_stall > 0) begin
            m_stall--; mem_wait_n = 1'b0; mem_dq = 16'hBEEF;
          end else begin
            mem_wait_n = 1'b1; mem_dq = pat(maddr); maddr = maddr + 22'd1;
            exp_next = maddr; m_first = 0; m_did = 0;
          end
        end
      end
    end
  end

  // consumer
  always begin
    @(negedge clk);
    case (rd_mode)
      1:       rd_ready = cyc[0];
      2:       rd_ready = (cyc % 8) < 2;
      default: rd_ready = 1'b1;
    endcase
    #1;
    if (rd_valid && rd_ready) begin
      chk(rd_data === pat(exp_rd), "R4 R8 data", int'(rd_data), int'(pat(exp_rd)));
      exp_rd = exp_rd + 22'd1;
      rx++;
    end
  end

  task automatic run_xfer(input logic [21:0] a, input int n);
    @(negedge clk);
    exp_next = a; exp_rd = a; rx = 0; adv_count = 0; ce_max = 0; pin_viol = 0; addr_viol = 0;
    req_addr = a; req_len = 16'(n); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (n > 0) chk(req_ready == 1'b0 && xfer_err == 1'b0, "R12 busy/R6 clear", int'(req_ready), 0);
    while (!(req_ready && !rd_valid)) @(negedge clk);
    #2;
  endtask

  task automatic t_reset;
    chk(mem_ce_n && mem_adv_n && mem_oe_n, "R1 memory strobes", int'({mem_ce_n, mem_adv_n, mem_oe_n}), 7);
    chk(!rd_valid && req_ready && !xfer_err, "R1 host side", int'({rd_valid, req_ready, xfer_err}), 2);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(mem_ce_n && req_ready && !rd_valid, "R1 after release", int'({mem_ce_n, req_ready, rd_valid}), 6);
    chk(mem_clk == 1'b0, "R11 clock low", int'(mem_clk), 0);
    @(posedge clk); #1;
    chk(mem_clk == 1'b1, "R11 clock high", int'(mem_clk), 1);
  endtask

  task automatic t_basic;
    lat_code = 3'd2; stall_len = 0; lat_hi = 0; rd_mode = 0;
    run_xfer(22'h000108, 8);
    chk(rx == 8, "R8 word count", rx, 8);
    chk(adv_count == 1, "R2 one strobe", adv_count, 1);
    chk(pin_viol == 0, "R2 pin rules", pin_viol, 0);
    chk(addr_viol == 0, "R2 strobe address", addr_viol, 0);
  endtask

  task automatic t_latency;
    lat_code = 3'd3; lat_hi = 1; rd_mode = 0;
    run_xfer(22'h0002A5, 5);
    chk(rx == 5, "R3 latency ignores WAIT", rx, 5);
    lat_code = 3'd0; lat_hi = 0;
    run_xfer(22'h3FFFFE, 3);
    chk(rx == 3 && pin_viol == 0, "R3 zero latency", rx, 3);
  endtask

  task automatic t_stall_ok;
    lat_code = 3'd2; stall_len = 4; rd_mode = 0;
    run_xfer(22'h00003C, 10);
    chk(rx == 10, "R5 stall of 2xLC", rx, 10);
    chk(xfer_err == 1'b0, "R5 no error", int'(xfer_err), 0);
    chk(adv_count == 1, "R4 stall inside one burst", adv_count, 1);
  endtask

  task automatic t_stall_bad;
    lat_code = 3'd2; stall_len = 5; rd_mode = 0;
    run_xfer(22'h00003C, 10);
    chk(rx == 4, "R6 abandoned after timeout", rx, 4);
    chk(xfer_err == 1'b1, "R6 error flagged", int'(xfer_err), 1);
    chk(mem_ce_n == 1'b1, "R6 chip enable high", int'(mem_ce_n), 1);
    stall_len = 0;
    run_xfer(22'h000070, 2);
    chk(xfer_err == 1'b0 && rx == 2, "R6 cleared by next request", int'(xfer_err), 0);
  endtask

  task automatic t_cem;
    lat_code = 3'd1; stall_len = 0; rd_mode = 0;
    run_xfer(22'h000500, 100);
    chk(rx == 100, "R7 long transfer count", rx, 100);
    chk(ce_max == CEM, "R7 chip enable limit", ce_max, CEM);
    chk(adv_count == 3, "R7 split count", adv_count, 3);
    chk(addr_viol == 0, "R7 restart address", addr_viol, 0);
  endtask

  task automatic t_backpressure;
    lat_code = 3'd2; stall_len = 2;
    rd_mode = 1;
    run_xfer(22'h000A07, 40);
    chk(rx == 40 && addr_viol == 0, "R9 alternating ready", rx, 40);
    chk(pin_viol == 0, "R9 pin rules", pin_viol, 0);
    rd_mode = 2;
    run_xfer(22'h000C1E, 30);
    chk(rx == 30 && addr_viol == 0, "R9 bursty ready", rx, 30);
    chk(ce_max <= CEM, "R7 limit under back-pressure", ce_max, CEM);
    rd_mode = 0;
  endtask

  task automatic t_zero;
    run_xfer(22'h000123, 0);
    chk(adv_count == 0 && rx == 0, "R10 no memory cycle", adv_count, 0);
    chk(req_ready == 1'b1, "R10 ready again", int'(req_ready), 1);
  endtask

  initial begin
    rd_ready = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_basic;
    t_latency;
    t_stall_ok;
    t_stall_bad;
    t_cem;
    t_backpressure;
    t_zero;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule